// File: doc/BRIEF.md
# Programmable Running Average Filter

This block smooths the 10-bit conversion results of a single channel with a first-order recursive filter. Each accepted sample moves the filter state toward that sample by a fraction 1/N of the remaining distance. N is a power of two chosen by a 4-bit depth code held in a small configuration register. The filtered value is always available on the output as a 10-bit current data value. Inside the block the state is kept as a 24-bit fixed-point number, so truncation costs far less than one LSB even at the deepest setting.

A host can seed the filter by writing a 10-bit value straight into the current data value. A good seed shortens the time the output needs to settle. A synchronous reset command puts the block back into its power-up condition. It can be issued at any time and needs no pulse on the chip reset. The ADC and any channel sequencing sit outside this block. A sequencer presents one sample per conversion scan using a valid strobe.

Top module: `run_avg_filter`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the state becomes mid-scale. After the edge, `cur_data` reads 0x200 and the depth code reads 0 (N = 1).
- R2: A high `soft_rst` at a rising edge has the same effect as R1. It takes priority over `wr_en`, `cfg_we` and `smp_vld` in that cycle.
- R3: With depth code 0, an accepted sample replaces the state, and `cur_data` equals that sample after the edge.
- R4: For depth code k from 0 to 8, each edge with `smp_vld` high computes the new state as old + ((sample·2^14 − old) >>> k). The difference is signed and the shift is arithmetic, which realises N = 2^k.
- R5: Depth codes 9 to 15 behave exactly like code 8 (N = 256).
- R6: The state is 24 bits wide, with 10 integer bits above 14 fraction bits. `cur_data` is the integer part, truncated.
- R7: A high `wr_en` (without `soft_rst`) loads `wr_data` into the integer part and clears the fraction. A sample presented in the same cycle is dropped.
- R8: On an edge with none of `smp_vld`, `wr_en` or `soft_rst` high, the state and `cur_data` keep their value, whatever `smp_data` does.
- R9: A write with `cfg_we` stores `cfg_code` as the depth code, and the state is left untouched. The new code applies from the next accepted sample onward.
- R10: Every update lands between the old state and the scaled sample, inclusive. It never wraps past full scale or below zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| soft_rst | input | 1 | Synchronous reset command, returns state and depth code to defaults |
| cfg_we | input | 1 | Write strobe for the depth code |
| cfg_code | input | 4 | Depth code to store; N = 2^code, saturating at 256 |
| smp_vld | input | 1 | Sample strobe; one filter update per high cycle |
| smp_data | input | 10 | Conversion result to fold into the filter |
| wr_en | input | 1 | Host preload strobe for the current data value |
| wr_data | input | 10 | Preload value (integer part) |
| cur_data | output | 10 | Integer part of the filter state |

## Verification
On every clock, assertions check several properties. Reset and the reset command must leave mid-scale. A preload must land with a zero fraction. An idle cycle or a depth-code write must leave the state stable. Every update must stay between the old state and the sample without overflowing. Out-of-range codes must decode to the maximum shift. The exact filter arithmetic is checked only by the bench's scenarios: the values reached over a chain of samples at changing depths, truncation of fractional results, and the priority between simultaneous strobes. Those scenarios compare against values worked out by hand.

// File: rtl/avgf_pkg.sv
// Package avgf_pkg
// Shared widths and helpers for the running average filter.
// Assumes the sample is unsigned and the state is unsigned fixed point.
package avgf_pkg;
    localparam int DATA_W    = 10;  // sample / output width
    localparam int FRAC_W    = 14;  // fraction bits kept in the state
    localparam int CODE_W    = 4;   // depth code width
    localparam int MAX_SHIFT = 8;   // deepest filter, N = 2^MAX_SHIFT

    // Width needed to hold a shift amount from 0 up to MAX_SHIFT
    function automatic int shift_width(input int max_shift);
        return (max_shift < 2) ? 1 : $clog2(max_shift + 1);
    endfunction

    // Mid-scale value for a given data width
    function automatic int mid_scale(input int data_w);
        return 1 << (data_w - 1);
    endfunction
endpackage

// File: rtl/avgf_depth_dec.sv
// Module avgf_depth_dec
// Turns the stored depth code into a right-shift amount (log2 of N).
// Codes above MAX_SHIFT saturate at MAX_SHIFT. Purely combinational.
module avgf_depth_dec #(
    parameter int CODE_W    = 4,
    parameter int MAX_SHIFT = 8,
    parameter int SHIFT_W   = 4
) (
    input  logic [CODE_W-1:0]  code,
    output logic [SHIFT_W-1:0] shift
);
    localparam int CODE_MAX = (1 << CODE_W) - 1;

    generate
        if (CODE_MAX <= MAX_SHIFT) begin : g_no_sat
            // Every code is a legal depth, pass it through
            always_comb shift = SHIFT_W'(code);
        end else begin : g_sat
            // Clamp codes beyond the deepest setting
            always_comb begin
                if (int'(code) > MAX_SHIFT)
                    shift = SHIFT_W'(MAX_SHIFT);
                else
                    shift = SHIFT_W'(code);
            end
        end
    endgenerate
endmodule

// File: rtl/avgf_step.sv
// Module avgf_step
// One recursive averaging step: next = state + (sample<<FRAC_W - state) >>> shift.
// The difference is signed, one bit wider than the state, and the shift is
// arithmetic, so the result stays between state and the scaled sample.
// The output is one bit wider than the state; its top bit is zero for legal inputs.
module avgf_step #(
    parameter int DATA_W  = 10,
    parameter int FRAC_W  = 14,
    parameter int SHIFT_W = 4
) (
    input  logic [DATA_W+FRAC_W-1:0] state,
    input  logic [DATA_W-1:0]        sample,
    input  logic [SHIFT_W-1:0]       shift,
    output logic [DATA_W+FRAC_W:0]   next_ext,
    output logic [DATA_W+FRAC_W-1:0] target
);
    localparam int ACC_W = DATA_W + FRAC_W;

    logic signed [ACC_W:0] target_s;
    logic signed [ACC_W:0] state_s;
    logic signed [ACC_W:0] diff;
    logic signed [ACC_W:0] delta;
    logic signed [ACC_W:0] sum;

    // Scale the sample onto the state grid and form the signed step
    always_comb begin
        target   = {sample, {FRAC_W{1'b0}}};
        target_s = $signed({1'b0, target});
        state_s  = $signed({1'b0, state});
        diff     = target_s - state_s;
        delta    = diff >>> shift;
        sum      = state_s + delta;
        next_ext = sum;
    end
endmodule

// File: rtl/avgf_state.sv
// Module avgf_state
// Holds the 24-bit fixed-point filter state. Priority per edge:
// chip reset, reset command, host preload, sample update, hold.
// Assumes rst_n is held low for at least two clock edges.
module avgf_state #(
    parameter int DATA_W = 10,
    parameter int FRAC_W = 14
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     soft_rst,
    input  logic                     wr_en,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic                     upd_en,
    input  logic [DATA_W+FRAC_W-1:0] upd_val,
    output logic [DATA_W+FRAC_W-1:0] state
);
    localparam int ACC_W = DATA_W + FRAC_W;
    localparam logic [ACC_W-1:0] MID_STATE =
        {DATA_W'(avgf_pkg::mid_scale(DATA_W)), {FRAC_W{1'b0}}};

    // State register with reset, preload and update in priority order
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst)
            state <= MID_STATE;
        else if (wr_en)
            state <= {wr_data, {FRAC_W{1'b0}}};
        else if (upd_en)
            state <= upd_val;
    end

    // A reset command leaves mid-scale on the next cycle
    assert_reset_cmd_midscale_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(soft_rst) |-> state == MID_STATE);

    // A chip reset leaves mid-scale once reset releases
    assert_reset_midscale_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> state == MID_STATE);

    // A preload lands as integer part with a cleared fraction
    assert_preload_exact_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && !$past(soft_rst))
            |-> state == {$past(wr_data), {FRAC_W{1'b0}}});

    // With no strobe the state holds
    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(upd_en) && !$past(wr_en) && !$past(soft_rst))
            |-> $stable(state));
endmodule

// File: rtl/run_avg_filter.sv
// Module run_avg_filter
// Single-channel programmable running average filter. A depth code register
// selects N = 2^code (saturating at 2^MAX_SHIFT); each sample strobe folds the
// sample into a fixed-point state; the integer part is the current data value.
// Assumes a synchronous active-low reset held for at least two edges.
module run_avg_filter #(
    parameter int DATA_W    = avgf_pkg::DATA_W,
    parameter int FRAC_W    = avgf_pkg::FRAC_W,
    parameter int CODE_W    = avgf_pkg::CODE_W,
    parameter int MAX_SHIFT = avgf_pkg::MAX_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              cfg_we,
    input  logic [CODE_W-1:0] cfg_code,
    input  logic              smp_vld,
    input  logic [DATA_W-1:0] smp_data,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] cur_data
);
    localparam int ACC_W   = DATA_W + FRAC_W;
    localparam int SHIFT_W = avgf_pkg::shift_width(MAX_SHIFT);

    logic [CODE_W-1:0]  depth_code;
    logic [SHIFT_W-1:0] shift;
    logic [ACC_W-1:0]   state;
    logic [ACC_W:0]     next_ext;
    logic [ACC_W-1:0]   target;
    logic [ACC_W-1:0]   lo_bound;
    logic [ACC_W-1:0]   hi_bound;

    // Depth code register, cleared by either reset
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst)
            depth_code <= '0;
        else if (cfg_we)
            depth_code <= cfg_code;
    end

    avgf_depth_dec #(
        .CODE_W   (CODE_W),
        .MAX_SHIFT(MAX_SHIFT),
        .SHIFT_W  (SHIFT_W)
    ) u_dec (
        .code (depth_code),
        .shift(shift)
    );

    avgf_step #(
        .DATA_W (DATA_W),
        .FRAC_W (FRAC_W),
        .SHIFT_W(SHIFT_W)
    ) u_step (
        .state   (state),
        .sample  (smp_data),
        .shift   (shift),
        .next_ext(next_ext),
        .target  (target)
    );

    avgf_state #(
        .DATA_W(DATA_W),
        .FRAC_W(FRAC_W)
    ) u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .soft_rst(soft_rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .upd_en  (smp_vld),
        .upd_val (next_ext[ACC_W-1:0]),
        .state   (state)
    );

    // Output is the integer part of the state, fraction truncated
    assign cur_data = state[ACC_W-1:FRAC_W];

    // Bounds of a legal update, used only by the checks below
    always_comb begin
        lo_bound = (state < target) ? state : target;
        hi_bound = (state < target) ? target : state;
    end

    // Updates stay between old state and scaled sample and never carry out
    assert_update_in_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld |-> (next_ext[ACC_W] == 1'b0)
                 && (next_ext[ACC_W-1:0] >= lo_bound)
                 && (next_ext[ACC_W-1:0] <= hi_bound));

    // Codes past the deepest setting decode to the deepest shift
    assert_code_saturates_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(depth_code) > MAX_SHIFT) |-> shift == SHIFT_W'(MAX_SHIFT));

    // A depth code write alone leaves the state untouched
    assert_cfg_keeps_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cfg_we) && !$past(smp_vld) && !$past(wr_en) && !$past(soft_rst))
            |-> $stable(state));
endmodule

// File: tb/tb_run_avg_filter.sv
// Bench for run_avg_filter: a vector table of (code, sample, expected output)
// walked in order, then directed tests for resets, preload, hold and truncation.
module tb_run_avg_filter;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       soft_rst = 1'b0;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_code = '0;
    logic       smp_vld = 1'b0;
    logic [9:0] smp_data = '0;
    logic       wr_en = 1'b0;
    logic [9:0] wr_data = '0;
    logic [9:0] cur_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Each entry: {depth code, sample, expected cur_data}, from 0x200 start
    localparam logic [23:0] VEC [NVEC] = '{
        {4'd0,  10'd100,  10'd100},   // R3 N=1
        {4'd1,  10'd300,  10'd200},   // R4 N=2
        {4'd1,  10'd300,  10'd250},   // R4
        {4'd2,  10'd0,    10'd187},   // R4 R9 187.5 truncated
        {4'd2,  10'd0,    10'd140},   // R6 140.625
        {4'd3,  10'd1023, 10'd250},   // R4 250.92
        {4'd0,  10'd1023, 10'd1023},  // R3
        {4'd8,  10'd0,    10'd1019},  // R4 N=256
        {4'd15, 10'd0,    10'd1015},  // R5 code 15 as 256
        {4'd9,  10'd1023, 10'd1015}   // R5 code 9 as 256
    };

    run_avg_filter dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .soft_rst(soft_rst),
        .cfg_we  (cfg_we),
        .cfg_code(cfg_code),
        .smp_vld (smp_vld),
        .smp_data(smp_data),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cur_data(cur_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_code(input logic [3:0] c);
        @(negedge clk); cfg_we = 1'b1; cfg_code = c;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic send(input logic [9:0] d);
        @(negedge clk); smp_vld = 1'b1; smp_data = d;
        @(negedge clk); smp_vld = 1'b0;
    endtask

    task automatic preload(input logic [9:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset mid-scale", cur_data, 10'h200);

        // Vector table walk: R3 R4 R5 R6 R9
        for (int i = 0; i < NVEC; i++) begin
            set_code(VEC[i][23:20]);
            send(VEC[i][19:10]);
            check($sformatf("R4 R5 vector %0d", i), cur_data, VEC[i][9:0]);
        end

        // R8: no strobe, changing data, output holds
        @(negedge clk); smp_data = 10'd3;
        repeat (4) @(negedge clk);
        smp_data = 10'd700;
        @(negedge clk);
        check("R8 hold without strobe", cur_data, 10'd1015);

        // R9: depth write alone keeps the output
        set_code(4'd0);
        check("R9 code write keeps state", cur_data, 10'd1015);

        // R7: preload then a half step
        preload(10'd300);
        check("R7 preload value", cur_data, 10'd300);
        set_code(4'd1);
        send(10'd100);
        check("R7 step from preload", cur_data, 10'd200);

        // R7: write wins over a simultaneous sample
        @(negedge clk); wr_en = 1'b1; wr_data = 10'd400; smp_vld = 1'b1; smp_data = 10'd0;
        @(negedge clk); wr_en = 1'b0; smp_vld = 1'b0;
        check("R7 write beats sample", cur_data, 10'd400);

        // R6: truncation of fractional results
        preload(10'd0);
        send(10'd1);
        check("R6 0.5 truncates to 0", cur_data, 10'd0);
        send(10'd1);
        check("R6 0.75 truncates to 0", cur_data, 10'd0);
        send(10'd3);
        check("R6 1.875 truncates to 1", cur_data, 10'd1);

        // R2: reset command beats write and sample, clears code
        set_code(4'd3);
        @(negedge clk); soft_rst = 1'b1; wr_en = 1'b1; wr_data = 10'd9; smp_vld = 1'b1; smp_data = 10'd9;
        @(negedge clk); soft_rst = 1'b0; wr_en = 1'b0; smp_vld = 1'b0;
        check("R2 reset command mid-scale", cur_data, 10'h200);
        send(10'd5);
        check("R2 code back to 0", cur_data, 10'd5);

        // R1: chip reset mid-run restores defaults
        set_code(4'd4);
        send(10'd1000);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset mid-run", cur_data, 10'h200);
        send(10'd9);
        check("R1 code cleared", cur_data, 10'd9);

        finish_run();
    end
endmodule